// File: doc/BRIEF.md
# Dual-Channel Sample Interleaver Formatter

This block sits behind a dual-input converter whose words arrive as one stream with a valid strobe. It registers each accepted word as an 11-bit two's complement data value and a 3-bit range word, and tags it with a flag naming the input channel it belongs to. Two static select inputs choose the mode. With only one select set, every sample belongs to that channel at the full rate. With both set, the samples alternate A, B, A, B, so each channel gets half the rate. With neither set, the stream is ignored.

A companion capture clock runs at twice the sample rate. It is built from a phase counter on the system clock, not from a gated clock. The counter restarts on every accepted sample, so each output word is framed by two rising edges of the capture clock. The data, range and flag always change together, in the cycle where the capture clock is low.

Top module: `dual_ch_formatter`

## Requirements
- R1: One cycle after a clock edge that accepts a sample, `out_data` equals that edge's `smp_data` bit for bit (11-bit two's complement), `out_range` equals `smp_range`, and `out_chan_b` shows the channel of the same sample. All three update on that same edge.
- R2: On an edge that accepts no sample, `out_data`, `out_range` and `out_chan_b` keep their values.
- R3: With `sel_a`=1 and `sel_b`=0, every accepted sample carries `out_chan_b`=0 (channel A). With `sel_a`=0 and `sel_b`=1, every accepted sample carries `out_chan_b`=1 (channel B).
- R4: With both selects at 1 (diversity mode), successive accepted samples carry flags 0, 1, 0, 1, and so on. Each channel therefore gets every second sample.
- R5: The first sample accepted in diversity mode after reset, or after any change of the two selects, carries flag 0 (channel A). This holds even when the change and the sample fall on the same edge.
- R6: With both selects at 0, `smp_valid` is ignored, and the data, range and flag outputs hold.
- R7: Let n be the number of edges since the last accepting edge, taken modulo 4·QTR. Then `clk2x_out` is 1 exactly when floor(n/QTR) is odd. This gives two rising edges per 4·QTR-cycle sample period, and the clock is low in the first cycle after an update.
- R8: The capture-clock phase restarts on every accepted sample. With no samples it keeps running, wrapping every 4·QTR cycles.
- R9: During and just after reset, `out_data`, `out_range`, `out_chan_b` and `clk2x_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 1 | Static select for channel A |
| sel_b | input | 1 | Static select for channel B |
| smp_valid | input | 1 | Strobe marking a converter word |
| smp_data | input | DW (11) | Converter word, two's complement |
| smp_range | input | RW (3) | Range word for the same sample |
| out_data | output | DW (11) | Registered data word |
| out_range | output | RW (3) | Registered range word |
| out_chan_b | output | 1 | Channel flag: 0 = A, 1 = B |
| clk2x_out | output | 1 | Capture clock at twice the sample rate |

## Verification
The bench runs with QTR=2, which gives an 8-cycle sample period. The first stimulus uses samples at exactly that period in each select mode, with data at both two's-complement extremes and at -1. This separates a sign or bit-order fault from a channel-flag fault. Diversity runs are broken off after an odd number of samples by a detour through single-B mode and by a reset. These runs show whether the alternation restarts on A or wrongly carries on from its old state. Irregular spacing, back-to-back strobes and long idle gaps show whether the capture-clock phase is restarted by samples and runs free without them. Strobes sent with no mode selected show that ignored words leave the outputs untouched.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Mode code is {sel_a, sel_b}
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_B   = 2'b01,
    MODE_A   = 2'b10,
    MODE_DIV = 2'b11
  } fmt_mode_e;

  function automatic fmt_mode_e mode_decode(input logic a, input logic b);
    return fmt_mode_e'({a, b});
  endfunction

  // Channel flag for a sample: 0 = A, 1 = B. seq is the diversity turn.
  function automatic logic pick_chan(input fmt_mode_e m, input logic seq);
    case (m)
      MODE_B:   return 1'b1;
      MODE_DIV: return seq;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dcf_mode_seq.sv
module dcf_mode_seq
  import dcf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_a,
  input  logic      sel_b,
  input  logic      smp_valid,
  output logic      accept,
  output logic      mode_chg,
  output fmt_mode_e mode_cur,
  output logic      chan_flag,
  output logic      seq_b
);

  fmt_mode_e mode_q;
  logic      turn;

  assign mode_cur  = mode_decode(sel_a, sel_b);
  assign mode_chg  = (mode_cur != mode_q);
  assign accept    = smp_valid && (mode_cur != MODE_OFF);
  // A select change restarts the diversity turn on channel A
  assign turn      = mode_chg ? 1'b0 : seq_b;
  assign chan_flag = pick_chan(mode_cur, turn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      seq_b  <= 1'b0;
    end else begin
      mode_q <= mode_cur;
      if (accept)
        seq_b <= (mode_cur == MODE_DIV) ? ~chan_flag : 1'b0;
      else if (mode_chg)
        seq_b <= 1'b0;
    end
  end

endmodule

// File: rtl/dcf_clk2x.sv
module dcf_clk2x #(
  parameter int QTR = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  output logic clk2x_out
);

  localparam int SUB_W = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QTR - 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [1:0]       qtr_q, qtr_d;

  always_comb begin
    if (sync) begin
      sub_d = '0;
      qtr_d = 2'd0;
    end else if (sub_q == SUB_LAST) begin
      sub_d = '0;
      qtr_d = qtr_q + 2'd1;
    end else begin
      sub_d = sub_q + SUB_W'(1);
      qtr_d = qtr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q     <= '0;
      qtr_q     <= 2'd0;
      clk2x_out <= 1'b0;
    end else begin
      sub_q     <= sub_d;
      qtr_q     <= qtr_d;
      clk2x_out <= qtr_d[0];
    end
  end

endmodule

// File: rtl/dcf_word_reg.sv
module dcf_word_reg #(
  parameter int DW = 11,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d_in,
  input  logic [RW-1:0] r_in,
  input  logic          f_in,
  output logic [DW-1:0] d_out,
  output logic [RW-1:0] r_out,
  output logic          f_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= '0;
      r_out <= '0;
      f_out <= 1'b0;
    end else if (load) begin
      d_out <= d_in;
      r_out <= r_in;
      f_out <= f_in;
    end
  end

endmodule

// File: rtl/dual_ch_formatter.sv
module dual_ch_formatter
  import dcf_pkg::*;
#(
  parameter int DW  = 11,
  parameter int RW  = 3,
  parameter int QTR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [RW-1:0] smp_range,
  output logic [DW-1:0] out_data,
  output logic [RW-1:0] out_range,
  output logic          out_chan_b,
  output logic          clk2x_out
);

  // Internal events made visible for the checker
  logic      accept_w;
  logic      mode_chg_w;
  fmt_mode_e mode_w;
  logic      flag_w;
  logic      seq_b_w;
  logic      div_w;
  logic      off_w;

  assign div_w = (mode_w == MODE_DIV);
  assign off_w = (mode_w == MODE_OFF);

  dcf_mode_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .smp_valid (smp_valid),
    .accept    (accept_w),
    .mode_chg  (mode_chg_w),
    .mode_cur  (mode_w),
    .chan_flag (flag_w),
    .seq_b     (seq_b_w)
  );

  dcf_word_reg #(.DW(DW), .RW(RW)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_w),
    .d_in  (smp_data),
    .r_in  (smp_range),
    .f_in  (flag_w),
    .d_out (out_data),
    .r_out (out_range),
    .f_out (out_chan_b)
  );

  dcf_clk2x #(.QTR(QTR)) u_ck (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (accept_w),
    .clk2x_out (clk2x_out)
  );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int DW = 11,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept_w,
  input logic          mode_chg_w,
  input logic          div_w,
  input logic          off_w,
  input logic          sel_a,
  input logic          sel_b,
  input logic          seq_b_w,
  input logic [DW-1:0] smp_data,
  input logic [RW-1:0] smp_range,
  input logic [DW-1:0] out_data,
  input logic [RW-1:0] out_range,
  input logic          out_chan_b,
  input logic          clk2x_out
);

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (out_data == $past(smp_data)) && (out_range == $past(smp_range)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(out_data) && $stable(out_range) && $stable(out_chan_b));

  a_r3_single_a: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && sel_a && !sel_b) |=> !out_chan_b);

  a_r3_single_b: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !sel_a && sel_b) |=> out_chan_b);

  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && div_w) |=> (seq_b_w == !out_chan_b));

  a_r5_restart_a: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && div_w && mode_chg_w) |=> !out_chan_b);

  a_r6_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    off_w |=> $stable(out_data) && $stable(out_chan_b));

  a_r7_low_at_update: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !clk2x_out);

  a_r7_rise_on_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk2x_out) |-> $stable(out_data) && $stable(out_chan_b));

endmodule

bind dual_ch_formatter dcf_checker #(.DW(DW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_w   (accept_w),
  .mode_chg_w (mode_chg_w),
  .div_w      (div_w),
  .off_w      (off_w),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .seq_b_w    (seq_b_w),
  .smp_data   (smp_data),
  .smp_range  (smp_range),
  .out_data   (out_data),
  .out_range  (out_range),
  .out_chan_b (out_chan_b),
  .clk2x_out  (clk2x_out)
);

// File: tb/sim_dual_ch_formatter.sv
module sim_dual_ch_formatter;

  localparam int DW  = 11;
  localparam int RW  = 3;
  localparam int QTR = 2;
  localparam int PER = 4 * QTR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_a = 1'b0, sel_b = 1'b0, smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [RW-1:0] smp_range = '0;
  logic [DW-1:0] out_data;
  logic [RW-1:0] out_range;
  logic          out_chan_b, clk2x_out;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R9";

  always #2 clk = ~clk;  // 250 MHz

  dual_ch_formatter #(.DW(DW), .RW(RW), .QTR(QTR)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_range(smp_range),
    .out_data(out_data), .out_range(out_range),
    .out_chan_b(out_chan_b), .clk2x_out(clk2x_out)
  );

  // Behavioural reference model
  int m_data = 0, m_range = 0, m_flag = 0, m_clk = 0;
  int m_prev_mode = 0, m_turn = 0, m_since = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_range = 0; m_flag = 0; m_clk = 0;
      m_prev_mode = 0; m_turn = 0; m_since = 0;
    end else begin
      int md;
      md = sel_a * 2 + sel_b;
      if (md != m_prev_mode) m_turn = 0;
      if (smp_valid && md != 0) begin
        m_data  = smp_data;
        m_range = smp_range;
        if (md == 2) m_flag = 0;
        else if (md == 1) m_flag = 1;
        else begin
          m_flag = m_turn;
          m_turn = 1 - m_turn;
        end
        if (md != 3) m_turn = 0;
        m_since = 0;
      end else begin
        m_since = (m_since + 1) % PER;
      end
      m_clk = ((m_since / QTR) % 2 == 1) ? 1 : 0;
      m_prev_mode = md;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk({tag, " data"},  int'(out_data),   m_data);
      chk({tag, " range"}, int'(out_range),  m_range);
      chk({tag, " flag"},  int'(out_chan_b), m_flag);
      chk({tag, " R7 clk2x"}, int'(clk2x_out), m_clk);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One accepted-or-not strobe; checks the outputs in the following cycle
  task automatic send(input string req, input int d, input int r, input int exp_flag,
                      input int gap);
    int old_d;
    old_d = out_data;
    smp_valid = 1'b1; smp_data = DW'(d); smp_range = RW'(r);
    @(negedge clk);
    smp_valid = 1'b0;
    if (exp_flag < 0) begin
      chk({req, " ignored word"}, int'(out_data), old_d);
    end else begin
      chk({req, " data word"}, int'(out_data), d & ((1 << DW) - 1));
      chk({req, " flag"}, int'(out_chan_b), exp_flag);
      chk({req, " clk low after update"}, int'(clk2x_out), 0);
    end
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tag = "R9";
    chk("R9 reset data", int'(out_data), 0);
    chk("R9 reset clk2x", int'(clk2x_out), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    tag = "R3";
    sel_a = 1; sel_b = 0;
    send("R3 single A", 11'h400, 5, 0, PER - 1);   // most negative
    send("R1 single A", 11'h3FF, 2, 0, PER - 1);   // most positive
    send("R1 single A", 11'h7FF, 7, 0, PER - 1);   // -1
    sel_a = 0; sel_b = 1;
    send("R3 single B", 11'h155, 1, 1, PER - 1);
    send("R3 single B", 11'h2AA, 6, 1, PER - 1);

    tag = "R4";
    sel_a = 1; sel_b = 1;
    send("R5 first after change", 100, 0, 0, PER - 1);
    send("R4 div", 101, 1, 1, PER - 1);
    send("R4 div", 102, 2, 0, PER - 1);
    send("R4 div", 103, 3, 1, PER - 1);
    send("R4 div", 104, 4, 0, PER - 1);
    // detour through single B, then back: restart on A
    tag = "R5";
    sel_a = 0;
    send("R3 detour B", 200, 3, 1, 2);
    sel_a = 1;
    send("R5 after return", 201, 5, 0, PER - 1);
    send("R4 div", 202, 6, 1, PER - 1);
    send("R4 div", 203, 7, 0, 3);
    rst_n = 0; @(negedge clk);
    chk("R9 mid-run reset flag", int'(out_chan_b), 0);
    rst_n = 1; @(negedge clk);
    send("R5 after reset", 300, 2, 0, PER - 1);
    send("R4 div after reset", 301, 2, 1, 5);

    tag = "R8";
    send("R8 irregular", 400, 1, 0, 2);
    send("R8 irregular", 401, 1, 1, 0);
    send("R7 back to back", 402, 1, 0, 0);
    send("R7 back to back", 403, 1, 1, 3 * PER + 3);

    tag = "R6";
    sel_a = 0; sel_b = 0;
    send("R6 off", 500, 4, -1, 1);
    send("R6 off", 501, 4, -1, 2);
    chk("R6 flag held", int'(out_chan_b), 1);
    chk("R6 range held", int'(out_range), 1);
    repeat (PER) @(negedge clk);

    tag = "R2";
    sel_a = 1; sel_b = 1;
    send("R5 from off", 600, 0, 0, PER - 1);
    chk("R2 held after gap", int'(out_data), 600);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule